// File: doc/BRIEF.md
# Read Strobe Postamble Gating Logic

This block sits in the read capture path of a source-synchronous DDR-style memory interface. The memory drives a bidirectional data strobe. That strobe is held low for a preamble before its first valid edge and for a postamble after its last one, and then it floats. Ringing or noise while the line floats must never clock the data capture flops. The block takes the raw strobe from the pad and a read-window enable from the memory controller. It passes the strobe through only while a registered window enable is high and holds it at logic 0 at all other times.

The window enable opens half an I/O clock after the controller's request is sampled. The delay comes from a register clocked on the falling edge. The window closes with no added delay, because the undelayed rising-edge register also feeds the combining AND. Two reads that are not back-to-back are therefore always separated by a closed window, and a late postamble glitch from the first burst cannot get through.

A controller running at the I/O rate drives a one-bit enable. A controller running at a fraction of it drives one enable bit per I/O cycle, packed into a word, together with a tick that marks the I/O edges on which the slow clock launches a new word. All pins are plain control signals. No data stream crosses the block and there is no back-pressure.

Top module: `rdq_postamble_gate`

## Requirements
- R1: While `rst` is sampled high on a rising edge of `clk`, all enable registers clear, and `strobe_en` and `strobe_out` are 0 after that edge.
- R2: With RATIO=1, when `rd_en_word[0]` is sampled high on rising edge k after being sampled low on edge k-1, `strobe_en` stays low until the falling edge after k and is high from that falling edge on.
- R3: When the full-rate enable is sampled low on rising edge m, `strobe_en` is low immediately after edge m, with no half-cycle delay.
- R4: For as long as the full-rate enable is sampled high on consecutive rising edges, `strobe_en` stays high without a gap, including across the boundary between two bursts.
- R5: `strobe_out` equals `strobe_in` while `strobe_en` is 1, and is 0 while `strobe_en` is 0, even when `strobe_in` is X or Z.
- R6: A strobe pulse during a postamble after the window has closed, during the idle gap before a non-consecutive burst, or in the first half cycle of that next burst, never appears on `strobe_out`.
- R7: With RATIO=2, `rd_en_word` is sampled on rising edges where `hr_tick` is 1. `hr_tick` must be 1 on every second edge. Bit 0 of the sampled word becomes the full-rate enable on the next edge, and bit 1 becomes it on the edge after that.
- R8: With RATIO=2, `strobe_en` follows the serialized enable under the same rules as R2 and R3: high only from the falling edge after the serialized bit is set, and low as soon as the bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock; the rising edge samples, the falling edge delays the opening |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_word | input | RATIO | Read-window enable from the controller, one bit per I/O cycle, bit 0 first |
| hr_tick | input | 1 | Marks the edges on which a new enable word is taken (used only when RATIO>1) |
| strobe_in | input | 1 | Raw strobe from the pad, may float |
| strobe_en | output | 1 | Final window enable after the AND of both register stages |
| strobe_out | output | 1 | Gated strobe for the capture registers |

## Verification
At full rate, the gating is driven with a single-cycle read, a long read, two back-to-back bursts, and two bursts separated by an idle gap. These cases separate the half-cycle opening from the immediate closing and show that no gap appears inside a continuous window. Strobe glitches are placed in the postamble, in the idle gap, and in the first half cycle of the next burst, and X/Z is forced on the raw strobe while the window is closed. At half rate, the words 01, 10, 11 and 01-01 show that bit 0 goes first, that a window spanning two words stays open, and that two isolated bits produce two separate half-cycle-late windows.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
  // Width of a slot index for a given rate ratio, at least one bit.
  function automatic int slot_bits(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction
endpackage

// File: rtl/rdq_rate_adapter.sv
module rdq_rate_adapter #(
  parameter int RATIO = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RATIO-1:0] en_word,
  input  logic             load_tick,
  output logic             fr_en
);
  localparam int SW = rdq_pkg::slot_bits(RATIO);
  localparam logic [SW-1:0] LAST = SW'(RATIO - 1);

  generate
    if (RATIO == 1) begin : g_full
      logic unused_tick;
      assign unused_tick = load_tick;
      // Postamble register: the enable taken at full rate.
      always_ff @(posedge clk) begin
        if (rst) fr_en <= 1'b0;
        else     fr_en <= en_word[0];
      end
    end else begin : g_div
      logic [RATIO-1:0] word_q;
      logic [SW-1:0]    slot_q;
      // First-stage capture at the slow rate, then one bit per I/O edge.
      always_ff @(posedge clk) begin
        if (rst) begin
          word_q <= '0;
          slot_q <= '0;
          fr_en  <= 1'b0;
        end else begin
          fr_en <= word_q[slot_q];
          if (load_tick) begin
            word_q <= en_word;
            slot_q <= '0;
          end else if (slot_q != LAST) begin
            slot_q <= slot_q + 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rdq_en_gate.sv
module rdq_en_gate (
  input  logic clk,
  input  logic rst,
  input  logic fr_en,
  output logic gate_en
);
  logic late_q;
  // Falling-edge copy gives the half-cycle opening delay.
  always_ff @(negedge clk) begin
    if (rst) late_q <= 1'b0;
    else     late_q <= fr_en;
  end
  // The undelayed term closes the window at once.
  assign gate_en = fr_en & late_q;
endmodule

// File: rtl/rdq_strobe_mask.sv
module rdq_strobe_mask (
  input  logic gate_en,
  input  logic strobe_in,
  output logic strobe_out
);
  // Mux form keeps the output at a clean 0 whatever the pad carries.
  always_comb begin
    if (gate_en) strobe_out = strobe_in;
    else         strobe_out = 1'b0;
  end
endmodule

// File: rtl/rdq_postamble_gate.sv
module rdq_postamble_gate #(
  parameter int RATIO = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RATIO-1:0] rd_en_word,
  input  logic             hr_tick,
  input  logic             strobe_in,
  output logic             strobe_en,
  output logic             strobe_out
);
  logic fr_en;

  rdq_rate_adapter #(.RATIO(RATIO)) adapt_i (
    .clk       (clk),
    .rst       (rst),
    .en_word   (rd_en_word),
    .load_tick (hr_tick),
    .fr_en     (fr_en)
  );

  rdq_en_gate gate_i (
    .clk     (clk),
    .rst     (rst),
    .fr_en   (fr_en),
    .gate_en (strobe_en)
  );

  rdq_strobe_mask mask_i (
    .gate_en    (strobe_en),
    .strobe_in  (strobe_in),
    .strobe_out (strobe_out)
  );
endmodule

// File: rtl/rdq_postamble_gate_chk.sv
module rdq_postamble_gate_chk #(
  parameter int RATIO = 1
) (
  input logic             clk,
  input logic             rst,
  input logic [RATIO-1:0] rd_en_word,
  input logic             hr_tick,
  input logic             fr_en,
  input logic             strobe_en,
  input logic             strobe_out
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!strobe_en && !strobe_out)); // R1

  AST_OPEN_HALF_LATE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (strobe_en == fr_en)); // R2

  AST_CLOSE_AT_ONCE: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> (strobe_en == (fr_en && $past(fr_en)))); // R3

  AST_RUN_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && fr_en && $past(fr_en)) |-> strobe_en); // R4

  AST_CLOSED_IS_LOW: assert property (@(posedge clk) disable iff (rst)
    !strobe_en |-> (strobe_out == 1'b0)); // R5

  generate
    if (RATIO == 1) begin : g_full
      logic unused_tick;
      assign unused_tick = hr_tick;
      AST_FULL_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (fr_en == $past(rd_en_word[0]))); // R2
    end else begin : g_div
      AST_LOW_BIT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(hr_tick, 2))
          |-> (fr_en == $past(rd_en_word[0], 2))); // R7
    end
  endgenerate
endmodule

bind rdq_postamble_gate rdq_postamble_gate_chk #(.RATIO(RATIO)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .rd_en_word (rd_en_word),
  .hr_tick    (hr_tick),
  .fr_en      (fr_en),
  .strobe_en  (strobe_en),
  .strobe_out (strobe_out)
);

// File: tb/rdq_postamble_gate_tb_top.sv
`timescale 1ns/100ps
module rdq_postamble_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [0:0] rd_en = 1'b0;
  logic [1:0] en_word = 2'b00;
  logic       hr_tick = 1'b0;
  logic       strobe_in = 1'b0;
  logic       fr_se, fr_so, hr_se, hr_so;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  // Slow-clock tick: high on every second rising edge.
  always @(posedge clk) #1 hr_tick = ~hr_tick;

  rdq_postamble_gate #(.RATIO(1)) dut_i (
    .clk(clk), .rst(rst), .rd_en_word(rd_en), .hr_tick(hr_tick),
    .strobe_in(strobe_in), .strobe_en(fr_se), .strobe_out(fr_so));

  rdq_postamble_gate #(.RATIO(2)) dut_hr_i (
    .clk(clk), .rst(rst), .rd_en_word(en_word), .hr_tick(hr_tick),
    .strobe_in(strobe_in), .strobe_en(hr_se), .strobe_out(hr_so));

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic after_pos();
    @(posedge clk); #1;
  endtask

  task automatic after_neg();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; rd_en = 1'b1; en_word = 2'b11; strobe_in = 1'b1;
    after_pos(); after_pos();
    chk("R1 full enable in reset", fr_se, 1'b0);
    chk("R1 full strobe in reset", fr_so, 1'b0);
    chk("R1 half enable in reset", hr_se, 1'b0);
    after_neg();
    chk("R1 full enable in reset, falling", fr_se, 1'b0);
    rd_en = 1'b0; en_word = 2'b00; strobe_in = 1'b0;
    after_pos(); after_pos();
    rst = 1'b0;
    after_pos(); after_pos();
  endtask

  // Single-cycle read: opens half a cycle late, closes on the next edge.
  task automatic t_single();
    rd_en = 1'b1;
    after_pos(); rd_en = 1'b0;
    chk("R2 closed before falling edge", fr_se, 1'b0);
    after_neg();
    chk("R2 open after falling edge", fr_se, 1'b1);
    after_pos();
    chk("R3 closed at once", fr_se, 1'b0);
    after_neg();
    chk("R3 still closed", fr_se, 1'b0);
  endtask

  // Two bursts back to back: the window never drops.
  task automatic t_back2back();
    rd_en = 1'b1;
    after_pos();
    chk("R2 long read not yet open", fr_se, 1'b0);
    after_neg();
    for (int i = 0; i < 8; i++) begin
      after_pos();
      chk("R4 open at rising edge", fr_se, 1'b1);
      after_neg();
      chk("R4 open at falling edge", fr_se, 1'b1);
    end
    rd_en = 1'b0;
    after_pos();
    chk("R3 closed after long read", fr_se, 1'b0);
    after_pos();
  endtask

  // Pass-through while open, clean 0 with X/Z while closed.
  task automatic t_passthru();
    rd_en = 1'b1;
    after_pos(); after_neg();
    strobe_in = 1'b1; #0.5;
    chk("R5 strobe high passes", fr_so, 1'b1);
    strobe_in = 1'b0; #0.5;
    chk("R5 strobe low passes", fr_so, 1'b0);
    rd_en = 1'b0;
    after_pos();
    strobe_in = 1'bx; #0.5;
    chk("R5 X masked", fr_so, 1'b0);
    strobe_in = 1'bz; #0.5;
    chk("R5 Z masked", fr_so, 1'b0);
    strobe_in = 1'b0;
    after_pos();
  endtask

  // Glitches in the postamble, the gap and the start of the next burst.
  task automatic t_glitch();
    rd_en = 1'b1;
    after_pos(); after_neg();
    after_pos(); after_neg();
    rd_en = 1'b0;
    after_pos();
    strobe_in = 1'b1; #0.5;
    chk("R6 postamble glitch blocked", fr_so, 1'b0);
    strobe_in = 1'b0;
    for (int i = 0; i < 2; i++) begin
      after_pos();
      strobe_in = 1'b1; #0.5;
      chk("R6 gap glitch blocked", fr_so, 1'b0);
      strobe_in = 1'b0;
    end
    rd_en = 1'b1;
    after_pos();
    strobe_in = 1'b1; #0.5;
    chk("R6 first half of next burst blocked", fr_so, 1'b0);
    after_neg();
    chk("R5 next burst passes strobe", fr_so, 1'b1);
    strobe_in = 1'b0;
    rd_en = 1'b0;
    after_pos(); after_pos();
  endtask

  // Half rate: two words, then idle; expected bits follow R7, timing R8.
  task automatic t_half(input logic [1:0] wa, input logic [1:0] wb, input string tag);
    logic [6:0] b;
    b = {2'b00, wb[1], wb[0], wa[1], wa[0], 1'b0};
    do begin @(posedge clk); #1.5; end while (!hr_tick);
    en_word = wa;
    @(posedge clk); #1.5;
    for (int j = 1; j <= 6; j++) begin
      @(posedge clk); #1;
      chk($sformatf("R7 %s rising slot %0d", tag, j), hr_se, b[j] & b[j-1]);
      #0.5;
      if (j == 1) en_word = wb;
      if (j == 3) en_word = 2'b00;
      after_neg();
      chk($sformatf("R8 %s falling slot %0d", tag, j), hr_se, b[j]);
    end
    after_pos(); after_pos();
  endtask

  initial begin
    #(5.0 * 50000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    t_reset();
    t_single();
    t_back2back();
    t_passthru();
    t_glitch();
    t_half(2'b01, 2'b00, "low bit only");
    t_half(2'b10, 2'b01, "span across words");
    t_half(2'b11, 2'b11, "four cycles");
    t_half(2'b01, 2'b01, "isolated bits");
    report();
  end
endmodule